// File: doc/BRIEF.md
# Compatibility trap mode controller

This block keeps the mode triggers that let an older program run unchanged on a newer processor: floating-point trap mode, storage nullification, select trap and copy trap. It also drives the simulate indicator. Mode-control instructions set or clear these triggers. At each instruction boundary the block looks at the class of the decoded instruction and decides whether to let it run, trap it into the compatibility handler, or stop the machine with an I/O check.

A trap runs a fixed two-step sequence. In the first cycle the return address (instruction address plus one) is written into the address field of a fixed vector word. In the second cycle the program counter is loaded with the handler entry, which is the vector plus one for select and sense instructions and the vector plus two for copy-class instructions. Taking a trap clears nullification, both trap modes and the simulate indicator, so the store can reach high memory. The block also supplies the nullify-enable flag and the lowest blocked address to an external address gate. It supplies the floating-point trap decision to the arithmetic unit.

Top module: `compat_trap_ctrl`

## Requirements
- R1: After rst_ni is released, fp_mode_o is 1 and null_en_o, simulate_o, io_check_o, vec_we_o and pc_load_o are 0, with ready_o at 1.
- R2: mode_op_i code 1 turns floating-point trap mode on and code 2 turns it off, as seen on fp_mode_o. fp_trap_o equals fp_ovf_i while the mode is on and stays 0 while it is off.
- R3: mode_op_i code 3 sets null_en_o and simulate_o. In the next cycle pc_load_o is 1 with pc_next_o equal to operand_i, and ready_o is 0. mode_op_i code 4 clears null_en_o only and leaves simulate_o unchanged.
- R4: null_base_o is 2^(AW-1) (upper half blocked) when range_wide_i is 0, and 2^(AW-2) (upper three quarters blocked) when it is 1.
- R5: With select trap mode on (set by mode_op_i code 5), an accepted instruction of instr_class_i 1 (select/sense) traps. One cycle later vec_we_o is 1 and vec_data_o is (instr_pc_i + 1) mod 2^AW. One cycle after that pc_load_o is 1 with pc_next_o equal to vector + 1.
- R6: With copy trap mode on (set by mode_op_i code 6), an accepted instruction of class 2 (copy) or class 3 (locate drum) traps with the same store. The branch goes to vector + 2.
- R7: The vector word address is 2^(AW-1) when big_store_i is 1 and 2^(AW-3) when it is 0. For AW=15 these are octal 40000 and octal 10000.
- R8: A trap clears nullification, select trap mode, copy trap mode and the simulate indicator. null_en_o and simulate_o are already 0 in the store cycle, and a later instruction of the same class no longer traps.
- R9: An accepted instruction of class 2 or 3 while copy trap mode is off sets io_check_o, and ready_o stays 0 until console_rst_i. A class 1 instruction while select trap mode is off does not trap.
- R10: ready_o is 0 during both sequence cycles. An instruction presented then, including its mode operation, has no effect.
- R11: A console_rst_i pulse sets floating-point trap mode and clears nullification, both trap modes, the simulate indicator, io_check_o and any sequence in progress.
- R12: When both trap modes are on, the instruction class alone picks the handler offset, and exactly one store and one branch follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| console_rst_i | input | 1 | Console reset/clear/load pulse |
| instr_valid_i | input | 1 | Decoded instruction presented at a boundary |
| instr_class_i | input | 2 | 0 other, 1 select/sense, 2 copy, 3 locate drum |
| mode_op_i | input | 3 | 0 none, 1 fp on, 2 fp off, 3 nullify on+jump, 4 nullify off, 5 select trap on, 6 copy trap on |
| instr_pc_i | input | AW | Address of the presented instruction |
| operand_i | input | AW | Operand address (jump target for code 3) |
| big_store_i | input | 1 | Full-size store fitted |
| range_wide_i | input | 1 | Nullify range switch: 1 blocks upper three quarters |
| fp_ovf_i | input | 1 | Floating-point overflow/underflow event |
| ready_o | output | 1 | Block accepts an instruction this cycle |
| fp_mode_o | output | 1 | Floating-point trap mode; 0 permits overflow triggers and the MQ overflow test |
| fp_trap_o | output | 1 | Floating-point trap request |
| null_en_o | output | 1 | Storage nullification active |
| null_base_o | output | AW | Lowest blocked address |
| simulate_o | output | 1 | Simulate indicator |
| vec_we_o | output | 1 | Write address field of vector word |
| vec_addr_o | output | AW | Vector word address |
| vec_data_o | output | AW | Return address written into the address field |
| pc_load_o | output | 1 | Load program counter |
| pc_next_o | output | AW | New program counter value |
| io_check_o | output | 1 | I/O check raised, machine halted |

## Verification
The hardest case to reach is the one where both trap modes are armed, nullification is on, and a trap must clear all of them in the same cycle. The trap must also ignore an instruction pushed at the block during its busy cycles. The bench arms every trigger before each trap of a sweep over class, store size and boundary addresses, including the top address, whose return address wraps to zero. It holds a mode-off request on the inputs through the store cycle, then replays the same class to check that nothing traps again. For copy classes the replay must instead raise the check, which the bench then clears with a console pulse.

// File: rtl/compat_trap_pkg.sv
package compat_trap_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_SELECT = 2'd1,
    CLS_COPY   = 2'd2,
    CLS_LOCATE = 2'd3
  } instr_cls_e;

  typedef enum logic [2:0] {
    MOP_NONE     = 3'd0,
    MOP_FP_ON    = 3'd1,
    MOP_FP_OFF   = 3'd2,
    MOP_NULL_ON  = 3'd3,
    MOP_NULL_OFF = 3'd4,
    MOP_SEL_ON   = 3'd5,
    MOP_CPY_ON   = 3'd6
  } mode_op_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STORE = 2'd1,
    SEQ_JUMP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/compat_mode_regs.sv
module compat_mode_regs
  import compat_trap_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     console_i,
  input  logic     mode_take_i,
  input  mode_op_e op_i,
  input  logic     trap_i,
  output logic     fp_mode_o,
  output logic     null_o,
  output logic     sel_o,
  output logic     cpy_o,
  output logic     sim_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_mode_o <= 1'b1;
      null_o    <= 1'b0;
      sel_o     <= 1'b0;
      cpy_o     <= 1'b0;
      sim_o     <= 1'b0;
    end else if (console_i) begin
      fp_mode_o <= 1'b1;
      null_o    <= 1'b0;
      sel_o     <= 1'b0;
      cpy_o     <= 1'b0;
      sim_o     <= 1'b0;
    end else if (trap_i) begin
      null_o <= 1'b0;
      sel_o  <= 1'b0;
      cpy_o  <= 1'b0;
      sim_o  <= 1'b0;
    end else if (mode_take_i) begin
      case (op_i)
        MOP_FP_ON:    fp_mode_o <= 1'b1;
        MOP_FP_OFF:   fp_mode_o <= 1'b0;
        MOP_NULL_ON:  begin null_o <= 1'b1; sim_o <= 1'b1; end
        MOP_NULL_OFF: null_o <= 1'b0;
        MOP_SEL_ON:   begin sel_o <= 1'b1; sim_o <= 1'b1; end
        MOP_CPY_ON:   begin cpy_o <= 1'b1; sim_o <= 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/compat_null_range.sv
module compat_null_range #(
  parameter int unsigned AW = 15
) (
  input  logic          wide_i,
  output logic [AW-1:0] base_o
);
  localparam logic [AW-1:0] BaseHalf    = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] BaseQuarter = AW'(1) << (AW - 2);

  assign base_o = wide_i ? BaseQuarter : BaseHalf;
endmodule

// File: rtl/compat_trap_seq.sv
module compat_trap_seq
  import compat_trap_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          console_i,
  input  logic          valid_i,
  input  instr_cls_e    cls_i,
  input  mode_op_e      op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] operand_i,
  input  logic          big_store_i,
  input  logic          sel_mode_i,
  input  logic          cpy_mode_i,
  output logic          ready_o,
  output logic          trap_o,
  output logic          mode_take_o,
  output logic          vec_we_o,
  output logic [AW-1:0] vec_addr_o,
  output logic [AW-1:0] vec_data_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_next_o,
  output logic          io_check_o
);
  localparam logic [AW-1:0] VecLarge = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] VecSmall = AW'(1) << (AW - 3);

  seq_state_e    state_q;
  logic [AW-1:0] ret_q, vec_q, tgt_q;
  logic          chk_q;
  logic          take, copy_cls, sel_hit, cpy_hit, chk_hit;
  logic [AW-1:0] vec_sel;

  assign copy_cls    = (cls_i == CLS_COPY) || (cls_i == CLS_LOCATE);
  assign sel_hit     = (cls_i == CLS_SELECT) && sel_mode_i;
  assign cpy_hit     = copy_cls && cpy_mode_i;
  assign chk_hit     = copy_cls && !cpy_mode_i;
  assign ready_o     = (state_q == SEQ_IDLE) && !chk_q;
  assign take        = valid_i && ready_o;
  assign trap_o      = take && (sel_hit || cpy_hit);
  assign mode_take_o = take && !sel_hit && !copy_cls;
  assign vec_sel     = big_store_i ? VecLarge : VecSmall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ret_q   <= '0;
      vec_q   <= '0;
      tgt_q   <= '0;
      chk_q   <= 1'b0;
    end else if (console_i) begin
      state_q <= SEQ_IDLE;
      chk_q   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (trap_o) begin
            state_q <= SEQ_STORE;
            ret_q   <= pc_i + AW'(1);
            vec_q   <= vec_sel;
            // class alone picks the handler entry
            tgt_q   <= vec_sel + (copy_cls ? AW'(2) : AW'(1));
          end else if (take && chk_hit) begin
            chk_q <= 1'b1;
          end else if (mode_take_o && op_i == MOP_NULL_ON) begin
            state_q <= SEQ_JUMP;
            tgt_q   <= operand_i;
          end
        end
        SEQ_STORE: state_q <= SEQ_JUMP;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign vec_we_o   = (state_q == SEQ_STORE);
  assign vec_addr_o = vec_q;
  assign vec_data_o = ret_q;
  assign pc_load_o  = (state_q == SEQ_JUMP);
  assign pc_next_o  = tgt_q;
  assign io_check_o = chk_q;
endmodule

// File: rtl/compat_trap_ctrl.sv
module compat_trap_ctrl
  import compat_trap_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          console_rst_i,
  input  logic          instr_valid_i,
  input  logic [1:0]    instr_class_i,
  input  logic [2:0]    mode_op_i,
  input  logic [AW-1:0] instr_pc_i,
  input  logic [AW-1:0] operand_i,
  input  logic          big_store_i,
  input  logic          range_wide_i,
  input  logic          fp_ovf_i,
  output logic          ready_o,
  output logic          fp_mode_o,
  output logic          fp_trap_o,
  output logic          null_en_o,
  output logic [AW-1:0] null_base_o,
  output logic          simulate_o,
  output logic          vec_we_o,
  output logic [AW-1:0] vec_addr_o,
  output logic [AW-1:0] vec_data_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_next_o,
  output logic          io_check_o
);
  logic       trap, mode_take, sel_mode, cpy_mode;
  instr_cls_e cls;
  mode_op_e   op;

  assign cls = instr_cls_e'(instr_class_i);
  assign op  = mode_op_e'(mode_op_i);

  compat_trap_seq #(.AW(AW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .console_i   (console_rst_i),
    .valid_i     (instr_valid_i),
    .cls_i       (cls),
    .op_i        (op),
    .pc_i        (instr_pc_i),
    .operand_i   (operand_i),
    .big_store_i (big_store_i),
    .sel_mode_i  (sel_mode),
    .cpy_mode_i  (cpy_mode),
    .ready_o     (ready_o),
    .trap_o      (trap),
    .mode_take_o (mode_take),
    .vec_we_o    (vec_we_o),
    .vec_addr_o  (vec_addr_o),
    .vec_data_o  (vec_data_o),
    .pc_load_o   (pc_load_o),
    .pc_next_o   (pc_next_o),
    .io_check_o  (io_check_o)
  );

  compat_mode_regs i_modes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .console_i   (console_rst_i),
    .mode_take_i (mode_take),
    .op_i        (op),
    .trap_i      (trap),
    .fp_mode_o   (fp_mode_o),
    .null_o      (null_en_o),
    .sel_o       (sel_mode),
    .cpy_o       (cpy_mode),
    .sim_o       (simulate_o)
  );

  compat_null_range #(.AW(AW)) i_range (
    .wide_i (range_wide_i),
    .base_o (null_base_o)
  );

  assign fp_trap_o = fp_ovf_i && fp_mode_o;
endmodule

// File: rtl/compat_trap_ctrl_chk.sv
module compat_trap_ctrl_chk #(
  parameter int unsigned AW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          console_rst_i,
  input logic [AW-1:0] instr_pc_i,
  input logic          big_store_i,
  input logic          ready_o,
  input logic          fp_mode_o,
  input logic          fp_trap_o,
  input logic          null_en_o,
  input logic          simulate_o,
  input logic          vec_we_o,
  input logic [AW-1:0] vec_addr_o,
  input logic [AW-1:0] vec_data_o,
  input logic          pc_load_o,
  input logic          io_check_o
);
  localparam logic [AW-1:0] VecLarge = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] VecSmall = AW'(1) << (AW - 3);

  p_fp_off_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_mode_o |-> !fp_trap_o);

  p_ret_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_we_o |-> vec_data_o == instr_pc_i_d + AW'(1));

  p_vec_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_we_o |-> vec_addr_o == (big_d ? VecLarge : VecSmall));

  p_trap_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_we_o |-> (!null_en_o && !simulate_o));

  p_check_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_check_o && !console_rst_i) |=> io_check_o);

  p_store_then_jump_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_we_o && !console_rst_i) |=> pc_load_o);

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_we_o || pc_load_o) |-> !ready_o);

  p_console_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    console_rst_i |=> (fp_mode_o && !null_en_o && !simulate_o && !io_check_o));

  p_one_store_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_we_o |=> !vec_we_o);

  // one-cycle history kept here so nothing samples before reset
  logic [AW-1:0] instr_pc_i_d;
  logic          big_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_pc_i_d <= '0;
      big_d        <= 1'b0;
    end else begin
      instr_pc_i_d <= instr_pc_i;
      big_d        <= big_store_i;
    end
  end
endmodule

bind compat_trap_ctrl compat_trap_ctrl_chk #(.AW(AW)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .console_rst_i (console_rst_i),
  .instr_pc_i    (instr_pc_i),
  .big_store_i   (big_store_i),
  .ready_o       (ready_o),
  .fp_mode_o     (fp_mode_o),
  .fp_trap_o     (fp_trap_o),
  .null_en_o     (null_en_o),
  .simulate_o    (simulate_o),
  .vec_we_o      (vec_we_o),
  .vec_addr_o    (vec_addr_o),
  .vec_data_o    (vec_data_o),
  .pc_load_o     (pc_load_o),
  .io_check_o    (io_check_o)
);

// File: tb/test_compat_trap_ctrl.sv
`timescale 1ns/1ps
module test_compat_trap_ctrl;
  localparam int AW = 15;
  localparam logic [AW-1:0] MASK = '1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          console_rst_i = 1'b0;
  logic          instr_valid_i = 1'b0;
  logic [1:0]    instr_class_i = '0;
  logic [2:0]    mode_op_i = '0;
  logic [AW-1:0] instr_pc_i = '0;
  logic [AW-1:0] operand_i = '0;
  logic          big_store_i = 1'b1;
  logic          range_wide_i = 1'b0;
  logic          fp_ovf_i = 1'b0;
  logic          ready_o, fp_mode_o, fp_trap_o, null_en_o, simulate_o;
  logic          vec_we_o, pc_load_o, io_check_o;
  logic [AW-1:0] null_base_o, vec_addr_o, vec_data_o, pc_next_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  compat_trap_ctrl #(.AW(AW)) i_compat_trap_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .console_rst_i(console_rst_i),
    .instr_valid_i(instr_valid_i), .instr_class_i(instr_class_i),
    .mode_op_i(mode_op_i), .instr_pc_i(instr_pc_i), .operand_i(operand_i),
    .big_store_i(big_store_i), .range_wide_i(range_wide_i), .fp_ovf_i(fp_ovf_i),
    .ready_o(ready_o), .fp_mode_o(fp_mode_o), .fp_trap_o(fp_trap_o),
    .null_en_o(null_en_o), .null_base_o(null_base_o), .simulate_o(simulate_o),
    .vec_we_o(vec_we_o), .vec_addr_o(vec_addr_o), .vec_data_o(vec_data_o),
    .pc_load_o(pc_load_o), .pc_next_o(pc_next_o), .io_check_o(io_check_o)
  );

  task automatic chk(input string rq, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // present one instruction for one cycle; returns at the negedge after acceptance
  task automatic issue(input int cls, input int op, input int pc, input int opnd);
    @(negedge clk);
    instr_valid_i = 1'b1;
    instr_class_i = 2'(cls);
    mode_op_i     = 3'(op);
    instr_pc_i    = AW'(pc);
    operand_i     = AW'(opnd);
    @(negedge clk);
    instr_valid_i = 1'b0;
    instr_class_i = '0;
    mode_op_i     = '0;
  endtask

  task automatic console();
    @(negedge clk);
    console_rst_i = 1'b1;
    @(negedge clk);
    console_rst_i = 1'b0;
  endtask

  task automatic trap_case(input int big, input int cls, input int pc);
    logic [AW-1:0] vec;
    vec = (big != 0) ? AW'(1 << (AW - 1)) : AW'(1 << (AW - 3));
    big_store_i = big[0];
    issue(0, 6, 0, 0);                 // copy trap on
    issue(0, 5, 0, 0);                 // select trap on
    issue(0, 3, 0, 16'h0055);          // nullify on + jump
    @(negedge clk);
    instr_valid_i = 1'b1;
    instr_class_i = 2'(cls);
    mode_op_i     = 3'd0;
    instr_pc_i    = AW'(pc);
    @(negedge clk);                    // store cycle
    instr_class_i = 2'd0;
    mode_op_i     = 3'd2;              // held through busy cycles: must be ignored
    chk("R5 store strobe", vec_we_o, 1);
    chk("R5 return addr", vec_data_o, (pc + 1) & MASK);
    chk("R7 vector addr", vec_addr_o, vec);
    chk("R8 null cleared", null_en_o, 0);
    chk("R8 simulate off", simulate_o, 0);
    chk("R10 busy store", ready_o, 0);
    @(negedge clk);                    // jump cycle
    instr_valid_i = 1'b0;
    mode_op_i     = 3'd0;
    chk("R12 single store", vec_we_o, 0);
    chk("R10 busy jump", ready_o, 0);
    chk("R5/R6 pc load", pc_load_o, 1);
    chk(cls == 1 ? "R5 select entry" : "R6 copy entry", pc_next_o,
        (vec + ((cls == 1) ? 1 : 2)) & MASK);
    @(negedge clk);
    chk("R10 ignored op", fp_mode_o, 1);
    chk("R10 ready back", ready_o, 1);
    chk("R12 no second load", pc_load_o, 0);
    // replay: modes were cleared by the trap
    issue(cls, 0, pc, 0);
    chk("R8 no retrap", vec_we_o, 0);
    if (cls == 1) begin
      chk("R9 select passes", io_check_o, 0);
      chk("R9 select ready", ready_o, 1);
    end else begin
      chk("R9 check raised", io_check_o, 1);
      chk("R9 halted", ready_o, 0);
      console();
      chk("R11 check cleared", io_check_o, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_err++;
      n_vec++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #45 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 fp mode", fp_mode_o, 1);
    chk("R1 null", null_en_o, 0);
    chk("R1 simulate", simulate_o, 0);
    chk("R1 check", io_check_o, 0);
    chk("R1 ready", ready_o, 1);
    chk("R1 no store", vec_we_o, 0);
    chk("R1 no load", pc_load_o, 0);

    // R2 floating-point trap mode
    for (int v = 0; v < 2; v++) begin
      fp_ovf_i = v[0];
      #1 chk("R2 trap on", fp_trap_o, v);
    end
    issue(0, 2, 0, 0);
    chk("R2 mode off", fp_mode_o, 0);
    for (int v = 0; v < 2; v++) begin
      fp_ovf_i = v[0];
      #1 chk("R2 no trap off", fp_trap_o, 0);
    end
    issue(0, 1, 0, 0);
    chk("R2 mode on", fp_mode_o, 1);
    #1 chk("R2 trap again", fp_trap_o, 1);
    fp_ovf_i = 1'b0;

    // R4 range switch, with nullify off and on
    for (int n = 0; n < 2; n++) begin
      for (int w = 0; w < 2; w++) begin
        range_wide_i = w[0];
        #1 chk("R4 base", null_base_o, (w != 0) ? (1 << (AW - 2)) : (1 << (AW - 1)));
      end
      if (n == 0) issue(0, 3, 0, 0);
    end
    range_wide_i = 1'b0;
    console();

    // R3 enter/leave nullification
    issue(0, 3, 0, 16'h1234);
    chk("R3 null on", null_en_o, 1);
    chk("R3 simulate on", simulate_o, 1);
    chk("R3 jump", pc_load_o, 1);
    chk("R3 target", pc_next_o, 16'h1234);
    chk("R3 busy", ready_o, 0);
    @(negedge clk);
    chk("R3 ready", ready_o, 1);
    issue(0, 4, 0, 0);
    chk("R3 null off", null_en_o, 0);
    chk("R3 simulate kept", simulate_o, 1);
    chk("R3 no jump", pc_load_o, 0);

    // R11 console clears everything
    issue(0, 2, 0, 0);
    issue(0, 5, 0, 0);
    issue(0, 3, 0, 0);
    console();
    chk("R11 fp on", fp_mode_o, 1);
    chk("R11 null off", null_en_o, 0);
    chk("R11 simulate off", simulate_o, 0);
    issue(1, 0, 16'h0100, 0);
    chk("R11 select mode off", vec_we_o, 0);

    // R5..R10, R12 sweep
    for (int big = 0; big < 2; big++)
      for (int cls = 1; cls < 4; cls++)
        for (int k = 0; k < 4; k++)
          trap_case(big, cls, (k == 0) ? 0 : (k == 1) ? 16'h0123 : (k == 2) ? 16'h3FFF : 16'h7FFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule